// File: doc/BRIEF.md
# Row-Address-Folded SECDED Checker

This block protects words held in a DRAM-based cache against a failure that plain error-correcting codes miss. A broken row decoder can drive the wrong wordline. The array then returns a different row whose data and check bits still agree with each other, so a normal code reports the word as clean. The block closes that gap by mixing the row index into the code.

At write time, four copies of the 14-bit row index are XORed into the low 56 bits of the 64-bit word, placed side by side from bit 0 upward. The 8 check bits (seven Hamming bits plus one overall parity bit) are computed over that folded word, but the data is stored unfolded. At read time, the index of the row that was requested is folded in before the syndrome is formed. A mismatch between the requested row and the row actually read therefore shows up as an even, multi-bit difference, and the checker flags it as an address fault or an uncorrectable error.

The encoder is combinational. Reads pass through a valid/ready stream with one register stage, and each output beat carries the data (corrected where possible) and exactly one of three flags. An input is taken only when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new input is taken.

Top module: `rowfold_ecc`

## Requirements
- R1: `wr_chk` for data D and row r equals `wr_chk` for data D XOR {8'h00, r, r, r, r} and row 0. In other words, row bits are folded into data bits 0..55 and bits 56..63 are not folded.
- R2: A read whose data and check bits were written with the same row that is requested returns `out_clean`=1 and `out_data` equal to `rd_data`.
- R3: A read with exactly one flipped data bit (any of the 64) returns `out_corrected`=1 and the originally written data.
- R4: A read with exactly one flipped check bit (any of the 8) returns `out_corrected`=1 and the data unchanged.
- R5: A read of a consistent word written under row w, but requested as row r, where r XOR w has one or two bits set, returns `out_fault`=1.
- R6: A read of a consistent word requested under any row other than the one it was written with never returns `out_corrected`=1.
- R7: A read with exactly two flipped data bits and the correct row returns `out_fault`=1.
- R8: While `out_valid` is high, exactly one of `out_clean`, `out_corrected`, `out_fault` is set.
- R9: While `out_valid` is high and `out_ready` is low, `rd_ready` is low and the output beat stays stable. An accepted input appears at the output on the next cycle.
- R10: After reset, `out_valid` is low and `rd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 64 | Word being written |
| wr_row | input | 14 | Row index the word is written to |
| wr_chk | output | 8 | Check bits to store; bit 7 is overall parity |
| rd_valid | input | 1 | Read beat present |
| rd_ready | output | 1 | Read beat accepted this cycle when high with rd_valid |
| rd_data | input | 64 | Data returned by the array |
| rd_row | input | 14 | Row index that was requested |
| rd_chk | input | 8 | Check bits returned by the array |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | 64 | Data after correction |
| out_clean | output | 1 | No error seen |
| out_corrected | output | 1 | One bit error was repaired |
| out_fault | output | 1 | Wrong row or uncorrectable error |

## Verification
Every cycle, the assertions check four things: that exactly one flag is set, that the stream holds under back-pressure and moves accepted beats forward, that a clean beat passes its data unchanged, and that a corrected beat differs from its input in at most one bit. Whether a given wrong-row access is caught depends on the folding pattern and the code's column layout, so only the bench scenarios can show it. The same is true of the equivalence between folding and XORing the index into the data, and of the repair of every single-bit position. The bench therefore sweeps every data and check position, every single-bit row difference, random two-bit row differences, and arbitrary wrong rows.

// File: rtl/rowfold_pkg.sv
package rowfold_pkg;
  localparam int DATA_W = 64;
  localparam int ROW_W  = 14;
  localparam int COPIES = DATA_W / ROW_W;
  localparam int FOLD_W = COPIES * ROW_W;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;

  // Syndrome column of each data bit. Folded copy 0 uses distinct high bits
  // per index parity with index>>1 below; copies 1..3 share the index in the
  // low nibble so their sum leaves a Gray-coded column per index bit.
  function automatic logic [HAM_W-1:0] col_of(int i);
    logic [HAM_W-1:0] c;
    logic [3:0]       xv;
    int               q;
    int               k;
    if (i < FOLD_W) begin
      q  = i / ROW_W;
      xv = 4'((i % ROW_W) + 1);
      case (q)
        0:       c = {(xv[0] ? 3'b011 : 3'b001), 1'b0, xv[3:1]};
        1:       c = {3'b101, xv};
        2:       c = {3'b110, xv};
        default: c = {3'b111, xv};
      endcase
    end else begin
      k = i - FOLD_W;
      c = HAM_W'((k == 0) ? 3 : ((k < 4) ? k + 4 : k + 5));
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cover_mask(int k);
    logic [DATA_W-1:0] m;
    logic [HAM_W-1:0]  c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c    = col_of(i);
      m[i] = c[k];
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] fold_row(logic [DATA_W-1:0] d, logic [ROW_W-1:0] r);
    return d ^ DATA_W'({COPIES{r}});
  endfunction
endpackage

// File: rtl/rowfold_synd.sv
module rowfold_synd
  import rowfold_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [HAM_W-1:0]  ham_o,
  output logic              par_o
);
  logic [DATA_W-1:0] folded;
  assign folded = fold_row(data_i, row_i);

  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = cover_mask(k);
    assign ham_o[k] = ^(folded & MASK);
  end

  assign par_o = ^folded;
endmodule

// File: rtl/rowfold_decode.sv
module rowfold_decode
  import rowfold_pkg::*;
(
  input  logic [HAM_W-1:0]  syn_i,
  input  logic              par_i,
  output logic [DATA_W-1:0] flip_o,
  output logic              clean_o,
  output logic              corrected_o,
  output logic              fault_o
);
  logic [DATA_W-1:0] hit;
  logic              chk_pos;
  logic              single;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    localparam logic [HAM_W-1:0] COL = col_of(i);
    assign hit[i] = (syn_i == COL);
  end

  assign chk_pos     = (syn_i == '0) || $onehot(syn_i);
  assign single      = par_i && (chk_pos || (|hit));
  assign clean_o     = !par_i && (syn_i == '0);
  assign corrected_o = single;
  assign fault_o     = !clean_o && !single;
  assign flip_o      = par_i ? hit : '0;
endmodule

// File: rtl/rowfold_ecc.sv
module rowfold_ecc
  import rowfold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  wr_row,
  output logic [CHK_W-1:0]  wr_chk,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [CHK_W-1:0]  rd_chk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_clean,
  output logic              out_corrected,
  output logic              out_fault
);
  logic [HAM_W-1:0]  enc_ham, rd_ham, syn;
  logic              enc_par, rd_par, par_err;
  logic [DATA_W-1:0] flip;
  logic              d_clean, d_corr, d_fault, take;

  rowfold_synd i_enc_synd (.data_i(wr_data), .row_i(wr_row), .ham_o(enc_ham), .par_o(enc_par));
  assign wr_chk = {enc_par ^ (^enc_ham), enc_ham};

  rowfold_synd i_rd_synd (.data_i(rd_data), .row_i(rd_row), .ham_o(rd_ham), .par_o(rd_par));
  assign syn     = rd_ham ^ rd_chk[HAM_W-1:0];
  assign par_err = rd_par ^ (^rd_chk);

  rowfold_decode i_decode (
    .syn_i(syn), .par_i(par_err), .flip_o(flip),
    .clean_o(d_clean), .corrected_o(d_corr), .fault_o(d_fault)
  );

  assign rd_ready = !out_valid || out_ready;
  assign take     = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_clean     <= 1'b0;
      out_corrected <= 1'b0;
      out_fault     <= 1'b0;
    end else if (take) begin
      out_valid     <= 1'b1;
      out_data      <= rd_data ^ flip;
      out_clean     <= d_clean;
      out_corrected <= d_corr;
      out_fault     <= d_fault;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/rowfold_ecc_chk.sv
module rowfold_ecc_chk
  import rowfold_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_clean,
  input logic              out_corrected,
  input logic              out_fault
);
  // R8
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_clean, out_corrected, out_fault}));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable({out_clean, out_corrected, out_fault})));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !rd_ready);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> out_valid);

  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_clean && $past(rd_valid && rd_ready)) |-> (out_data == $past(rd_data)));

  // R3
  corr_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_corrected && $past(rd_valid && rd_ready))
      |-> ($countones(out_data ^ $past(rd_data)) <= 1));
endmodule

bind rowfold_ecc rowfold_ecc_chk i_rowfold_ecc_chk (.*);

// File: tb/test_rowfold_ecc.sv
`timescale 1ns/1ps
module test_rowfold_ecc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic [13:0] wr_row = '0;
  logic [7:0]  wr_chk;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [63:0] rd_data = '0;
  logic [13:0] rd_row = '0;
  logic [7:0]  rd_chk = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_clean, out_corrected, out_fault;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rowfold_ecc i_rowfold_ecc (.*);

  function automatic logic [63:0] rep(logic [13:0] r);
    return {8'h00, r, r, r, r};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enc(input logic [63:0] d, input logic [13:0] r, output logic [7:0] c);
    wr_data = d;
    wr_row  = r;
    #1;
    c = wr_chk;
  endtask

  task automatic rd(input logic [63:0] d, input logic [13:0] r, input logic [7:0] c);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_row = r; rd_chk = c;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  function automatic logic [2:0] flags();
    return {out_clean, out_corrected, out_fault};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d, d2;
    logic [13:0] r, w;
    logic [7:0]  c, c2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
    check(rd_ready == 1'b1, "R10 rd_ready", 64'(rd_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 folding equivalence
    for (int n = 0; n < 20; n++) begin
      d = rnd64(); r = (n == 0) ? 14'h3fff : 14'($urandom());
      enc(d, r, c);
      enc(d ^ rep(r), 14'd0, c2);
      check(c == c2, "R1 fold", 64'(c), 64'(c2));
    end

    // R2 matched rows, directed and random
    for (int n = 0; n < 30; n++) begin
      d = (n == 0) ? 64'd0 : ((n == 1) ? '1 : rnd64());
      r = (n == 0) ? 14'd0 : ((n == 1) ? 14'h3fff : 14'($urandom()));
      enc(d, r, c);
      rd(d, r, c);
      check(out_valid && flags() == 3'b100, "R2 clean flag", 64'(flags()), 64'h4);
      check(out_data == d, "R2 data", out_data, d);
      check($onehot(flags()), "R8 one flag", 64'(flags()), 64'h4);
    end

    // R3 every data bit
    for (int b = 0; b < 64; b++) begin
      d = rnd64(); r = 14'($urandom());
      enc(d, r, c);
      rd(d ^ (64'd1 << b), r, c);
      check(flags() == 3'b010 && out_data == d, "R3 data bit", out_data, d);
    end

    // R4 every check bit
    for (int b = 0; b < 8; b++) begin
      d = rnd64(); r = 14'($urandom());
      enc(d, r, c);
      rd(d, r, c ^ 8'(1 << b));
      check(flags() == 3'b010 && out_data == d, "R4 check bit", 64'(flags()), 64'h2);
    end

    // R5 wrong row, one differing index bit
    for (int b = 0; b < 14; b++) begin
      d = rnd64(); w = 14'($urandom());
      enc(d, w, c);
      rd(d, w ^ 14'(1 << b), c);
      check(flags() == 3'b001, "R5 one-bit row diff", 64'(flags()), 64'h1);
    end
    // R5 wrong row, two differing index bits
    for (int n = 0; n < 25; n++) begin
      int a, e;
      a = int'($urandom() % 14);
      e = int'((a + 1 + ($urandom() % 13)) % 14);
      d = rnd64(); w = 14'($urandom());
      enc(d, w, c);
      rd(d, w ^ 14'(1 << a) ^ 14'(1 << e), c);
      check(flags() == 3'b001, "R5 two-bit row diff", 64'(flags()), 64'h1);
    end

    // R6 arbitrary wrong row never corrected
    for (int n = 0; n < 30; n++) begin
      d = rnd64(); w = 14'($urandom());
      r = 14'($urandom());
      if (r == w) r = ~w;
      enc(d, w, c);
      rd(d, r, c);
      check(!out_corrected, "R6 no false repair", 64'(flags()), 64'h1);
    end

    // R7 two data bits flipped
    for (int n = 0; n < 20; n++) begin
      int a, e;
      a = int'($urandom() % 64);
      e = int'((a + 1 + ($urandom() % 63)) % 64);
      d = rnd64(); r = 14'($urandom());
      enc(d, r, c);
      rd(d ^ (64'd1 << a) ^ (64'd1 << e), r, c);
      check(flags() == 3'b001, "R7 double error", 64'(flags()), 64'h1);
    end

    // R9 back-pressure
    d = rnd64(); r = 14'($urandom()); enc(d, r, c);
    d2 = rnd64(); enc(d2, r, c2);
    @(negedge clk);
    out_ready = 1'b0;
    rd_valid = 1'b1; rd_data = d; rd_row = r; rd_chk = c;
    @(negedge clk);
    rd_data = d2; rd_chk = c2;
    check(out_valid && out_data == d, "R9 first beat", out_data, d);
    check(rd_ready == 1'b0, "R9 stall ready", 64'(rd_ready), 64'd0);
    @(negedge clk);
    check(out_valid && out_data == d, "R9 hold", out_data, d);
    out_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check(out_valid && out_data == d2 && out_clean, "R9 second beat", out_data, d2);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drain", 64'(out_valid), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule